// File: doc/BRIEF.md
# Crypto Keyslot Configuration Register File

This block keeps the per-slot encryption settings of a storage host controller. Each slot holds a 512-bit key, a data-unit-size mask, a capability index and an enable flag. Software reaches the slots through a small 32-bit register bus with byte addresses. The slot array begins at a byte offset of 256 times a pointer parameter, and each slot takes 32 dwords (128 bytes). The slot count is a configuration-count parameter plus one.

A datapath reads the settings through a lookup port. It presents a slot number and receives the key, mask, capability index and a valid flag one cycle later. A slot counts as valid only after its control dword has been written with the enable flag set. Any write to one of its key dwords withdraws that validity, so a key that is partly rewritten is never exposed. Software clears a slot by writing zero to every dword of it.

Top module: `ksr_regfile`

## Requirements
- R1: After reset every dword of every slot reads as zero and the lookup reports every slot invalid.
- R2: Dword d of slot s is at byte address ARRAY_PTR*256 + s*128 + d*4. Key dwords 0 to 15, control dword 16 and auxiliary dword 17 read back the last value written.
- R3: In the control dword, bits 7:0 are the data-unit-size mask, bits 15:8 are the capability index and bit 31 is the enable flag. All other bits are discarded on write and read as zero.
- R4: A slot becomes valid only in the cycle after its control dword is written with bit 31 set. While it is valid, the lookup returns key dword i on key bits 32i+31:32i, together with the mask and the capability index.
- R5: A write to any key dword of a slot clears that slot's enable flag. The control dword then reads with bit 31 at zero and the lookup reports the slot invalid until the control dword is written again with bit 31 set.
- R6: Writing zero to the control dword disables the slot. Writing zero to all dwords returns the slot to its reset contents.
- R7: Dwords 18 to 31 of a slot, and every address outside the slot array, read as zero and ignore writes. Such a write changes no slot.
- R8: A lookup of a slot number at or above the slot count, or of a disabled slot, returns valid 0 with key, mask and capability index all zero.
- R9: Read data and its valid strobe appear exactly one cycle after a read request, and the strobe is low in every other cycle.
- R10: A lookup result reflects the selected slot's state one cycle after the slot number is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| bus_wr_i | input | 1 | Write request |
| bus_rd_i | input | 1 | Read request |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, one cycle after a read request |
| bus_rvalid_o | output | 1 | Read data valid |
| lk_slot_i | input | clog2(CFG_COUNT+1)+1 | Lookup slot number |
| lk_valid_o | output | 1 | Looked-up slot is enabled |
| lk_key_o | output | 512 | Looked-up key |
| lk_dus_o | output | 8 | Looked-up data-unit-size mask |
| lk_cap_o | output | 8 | Looked-up capability index |

## Verification
The bench sweeps every slot and every implemented dword with values built from the slot and dword numbers, so any swapped slot, swapped dword or wrong offset shows up as a mismatch. Control writes that set every bit outside the defined fields confirm the field layout. Disabling a single slot, either by rewriting one of its key dwords or by writing zeros to it, shows that the change stays in that slot and that the lookup hides it until the slot is re-enabled. Writes to holes inside a slot and to addresses outside the array, followed by a full read-back and lookup of every slot, confirm that such writes change nothing. Lookups of numbers past the last slot confirm the range check.

// File: rtl/ksr_pkg.sv
package ksr_pkg;

    localparam int DWORD_W      = 32;
    localparam int KEY_DWORDS   = 16;
    localparam int KEY_W        = KEY_DWORDS * DWORD_W;
    localparam int CTRL_DWORD   = 16;
    localparam int AUX_DWORD    = 17;
    localparam int STRIDE_BYTES = 128;
    localparam int ARRAY_UNIT   = 256;
    localparam int DUS_W        = 8;
    localparam int CAP_W        = 8;
    localparam int EN_BIT       = 31;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_KEY,
        ACC_CTRL,
        ACC_AUX,
        ACC_HOLE
    } acc_kind_e;

    typedef struct packed {
        logic             en;
        logic [CAP_W-1:0] cap;
        logic [DUS_W-1:0] dus;
    } ctrl_t;

    typedef struct packed {
        logic             valid;
        logic [DUS_W-1:0] dus;
        logic [CAP_W-1:0] cap;
        logic [KEY_W-1:0] key;
    } slot_cfg_t;

    function automatic ctrl_t unpack_ctrl(input logic [DWORD_W-1:0] w);
        ctrl_t c;
        c.en  = w[EN_BIT];
        c.cap = w[DUS_W +: CAP_W];
        c.dus = w[0 +: DUS_W];
        return c;
    endfunction

    function automatic logic [DWORD_W-1:0] pack_ctrl(input ctrl_t c);
        logic [DWORD_W-1:0] w;
        w                 = '0;
        w[EN_BIT]         = c.en;
        w[DUS_W +: CAP_W] = c.cap;
        w[0 +: DUS_W]     = c.dus;
        return w;
    endfunction

    function automatic acc_kind_e classify(input logic [4:0] dw);
        if (dw < 5'(KEY_DWORDS))       return ACC_KEY;
        else if (dw == 5'(CTRL_DWORD)) return ACC_CTRL;
        else if (dw == 5'(AUX_DWORD))  return ACC_AUX;
        else                           return ACC_HOLE;
    endfunction

endpackage

// File: rtl/ksr_decode.sv
module ksr_decode
    import ksr_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int NUM_SLOTS = 4,
    parameter int ARRAY_PTR = 2,
    parameter int SLOT_W    = 2
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_o,
    output logic [SLOT_W-1:0] slot_o,
    output logic [4:0]        dword_o,
    output acc_kind_e         kind_o
);
    localparam int          OFF_W = ADDR_W + 8;
    localparam logic [OFF_W-1:0] BASE  = OFF_W'(ARRAY_PTR * ARRAY_UNIT);
    localparam logic [OFF_W-1:0] LIMIT = OFF_W'(ARRAY_PTR * ARRAY_UNIT + NUM_SLOTS * STRIDE_BYTES);

    logic [OFF_W-1:0] addr_ext;
    logic [OFF_W-1:0] off;

    always_comb begin
        addr_ext = OFF_W'(addr_i);
        off      = addr_ext - BASE;
        hit_o    = (addr_ext >= BASE) && (addr_ext < LIMIT);
        slot_o   = off[7 +: SLOT_W];
        dword_o  = off[6:2];
        kind_o   = hit_o ? classify(off[6:2]) : ACC_NONE;
    end
endmodule

// File: rtl/ksr_slot.sv
module ksr_slot
    import ksr_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               wr_i,
    input  acc_kind_e          kind_i,
    input  logic [4:0]         dword_i,
    input  logic [DWORD_W-1:0] wdata_i,
    output logic [DWORD_W-1:0] rdata_o,
    output slot_cfg_t          cfg_o
);
    logic [KEY_DWORDS-1:0][DWORD_W-1:0] key_q;
    ctrl_t                              ctrl_q;
    logic [DWORD_W-1:0]                 aux_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            key_q  <= '0;
            ctrl_q <= '0;
            aux_q  <= '0;
        end else if (wr_i) begin
            case (kind_i)
                ACC_KEY: begin
                    key_q[dword_i[3:0]] <= wdata_i;
                    ctrl_q.en           <= 1'b0;
                end
                ACC_CTRL: ctrl_q <= unpack_ctrl(wdata_i);
                ACC_AUX:  aux_q  <= wdata_i;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (kind_i)
            ACC_KEY:  rdata_o = key_q[dword_i[3:0]];
            ACC_CTRL: rdata_o = pack_ctrl(ctrl_q);
            ACC_AUX:  rdata_o = aux_q;
            default:  rdata_o = '0;
        endcase
        cfg_o.valid = ctrl_q.en;
        cfg_o.dus   = ctrl_q.en ? ctrl_q.dus : '0;
        cfg_o.cap   = ctrl_q.en ? ctrl_q.cap : '0;
        cfg_o.key   = ctrl_q.en ? key_q : '0;
    end

    // R5: a key write withdraws validity
    a_r5_key_write_drops: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_i && kind_i == ACC_KEY) |=> !cfg_o.valid);
    // R4: control write with enable makes the slot valid
    a_r4_enable_write: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_i && kind_i == ACC_CTRL && wdata_i[EN_BIT]) |=> cfg_o.valid);
    // R4: validity only rises through a control write
    a_r4_rise_needs_ctrl: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(cfg_o.valid) |-> $past(wr_i && kind_i == ACC_CTRL));
    // R7: holes never change the slot
    a_r7_hole_no_effect: assert property (@(posedge clk_i) disable iff (rst_i)
        (!wr_i || kind_i == ACC_HOLE || kind_i == ACC_NONE) |=> $stable(cfg_o));
endmodule

// File: rtl/ksr_lookup.sv
module ksr_lookup
    import ksr_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int SLOT_W    = 2,
    parameter int LK_W      = 3
) (
    input  logic      clk_i,
    input  logic      rst_i,
    input  slot_cfg_t cfg_i [NUM_SLOTS],
    input  logic [LK_W-1:0] slot_i,
    output slot_cfg_t q_o
);
    logic              in_range;
    logic [SLOT_W-1:0] sel;
    logic [NUM_SLOTS-1:0] vld;

    always_comb begin
        in_range = slot_i < LK_W'(NUM_SLOTS);
        sel      = slot_i[SLOT_W-1:0];
        for (int i = 0; i < NUM_SLOTS; i++) vld[i] = cfg_i[i].valid;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i)         q_o <= '0;
        else if (in_range) q_o <= cfg_i[sel];
        else               q_o <= '0;
    end

    // R8: out-of-range lookup is invalid and empty
    a_r8_out_of_range: assert property (@(posedge clk_i) disable iff (rst_i)
        !in_range |=> (!q_o.valid && q_o.key == '0));
    // R10: one-cycle latency of the valid flag
    a_r10_latency: assert property (@(posedge clk_i) disable iff (rst_i)
        in_range |=> (q_o.valid == $past(vld[sel])));
endmodule

// File: rtl/ksr_regfile.sv
module ksr_regfile
    import ksr_pkg::*;
#(
    parameter int CFG_COUNT = 3,
    parameter int ARRAY_PTR = 2,
    parameter int ADDR_W    = 12
) (
    input  logic                               clk_i,
    input  logic                               rst_i,
    input  logic                               bus_wr_i,
    input  logic                               bus_rd_i,
    input  logic [ADDR_W-1:0]                  bus_addr_i,
    input  logic [31:0]                        bus_wdata_i,
    output logic [31:0]                        bus_rdata_o,
    output logic                               bus_rvalid_o,
    input  logic [$clog2(CFG_COUNT+1):0]       lk_slot_i,
    output logic                               lk_valid_o,
    output logic [511:0]                       lk_key_o,
    output logic [7:0]                         lk_dus_o,
    output logic [7:0]                         lk_cap_o
);
    localparam int NUM_SLOTS = CFG_COUNT + 1;
    localparam int SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
    localparam int LK_W      = $clog2(CFG_COUNT + 1) + 1;

    logic              hit;
    logic [SLOT_W-1:0] slot;
    logic [4:0]        dword;
    acc_kind_e         kind;

    logic [DWORD_W-1:0] slot_rd [NUM_SLOTS];
    slot_cfg_t          slot_cfg [NUM_SLOTS];
    slot_cfg_t          lk_q;
    logic [DWORD_W-1:0] rdata_q;
    logic               rvalid_q;

    ksr_decode #(
        .ADDR_W   (ADDR_W),
        .NUM_SLOTS(NUM_SLOTS),
        .ARRAY_PTR(ARRAY_PTR),
        .SLOT_W   (SLOT_W)
    ) dec_i (
        .addr_i (bus_addr_i),
        .hit_o  (hit),
        .slot_o (slot),
        .dword_o(dword),
        .kind_o (kind)
    );

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        ksr_slot slot_i (
            .clk_i  (clk_i),
            .rst_i  (rst_i),
            .wr_i   (bus_wr_i && hit && slot == SLOT_W'(s)),
            .kind_i (kind),
            .dword_i(dword),
            .wdata_i(bus_wdata_i),
            .rdata_o(slot_rd[s]),
            .cfg_o  (slot_cfg[s])
        );
    end

    ksr_lookup #(
        .NUM_SLOTS(NUM_SLOTS),
        .SLOT_W   (SLOT_W),
        .LK_W     (LK_W)
    ) lk_i (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .cfg_i (slot_cfg),
        .slot_i(lk_slot_i),
        .q_o   (lk_q)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= bus_rd_i;
            rdata_q  <= (bus_rd_i && hit) ? slot_rd[slot] : '0;
        end
    end

    assign bus_rdata_o  = rdata_q;
    assign bus_rvalid_o = rvalid_q;
    assign lk_valid_o   = lk_q.valid;
    assign lk_key_o     = lk_q.key;
    assign lk_dus_o     = lk_q.dus;
    assign lk_cap_o     = lk_q.cap;

    // R9: strobe follows the request by one cycle
    a_r9_rvalid: assert property (@(posedge clk_i) disable iff (rst_i)
        bus_rvalid_o == $past(bus_rd_i));
    // R7: reads outside the array return zero
    a_r7_outside_zero: assert property (@(posedge clk_i) disable iff (rst_i)
        (bus_rd_i && !hit) |=> bus_rdata_o == '0);
    // R3: undefined control bits never read back
    a_r3_ctrl_reserved: assert property (@(posedge clk_i) disable iff (rst_i)
        (bus_rd_i && kind == ACC_CTRL) |=> bus_rdata_o[30:16] == '0);
endmodule

// File: tb/ksr_regfile_tb.sv
module ksr_regfile_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CFG_COUNT  = 3;
    localparam int NSLOT      = CFG_COUNT + 1;
    localparam int PTR        = 2;
    localparam int BASE       = PTR * 256;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr = 1'b0, rd = 1'b0;
    logic [11:0]  addr = '0;
    logic [31:0]  wdata = '0;
    logic [31:0]  rdata;
    logic         rvalid;
    logic [2:0]   lk_slot = '0;
    logic         lk_valid;
    logic [511:0] lk_key;
    logic [7:0]   lk_dus, lk_cap;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ksr_regfile #(.CFG_COUNT(CFG_COUNT), .ARRAY_PTR(PTR), .ADDR_W(12)) dut_i (
        .clk_i(clk), .rst_i(rst), .bus_wr_i(wr), .bus_rd_i(rd),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .bus_rvalid_o(rvalid), .lk_slot_i(lk_slot), .lk_valid_o(lk_valid),
        .lk_key_o(lk_key), .lk_dus_o(lk_dus), .lk_cap_o(lk_cap));

    function automatic logic [31:0] kval(int s, int d, int gen);
        return 32'h1000_0000 * (s + 1) + d * 32'h0001_0203 + 32'h55 + gen * 32'h0777;
    endfunction
    function automatic logic [7:0] dus_of(int s); return 8'h01 << s; endfunction
    function automatic logic [7:0] cap_of(int s); return 8'h10 + 8'(s); endfunction
    function automatic logic [11:0] a_of(int s, int d); return 12'(BASE + s * 128 + d * 4); endfunction
    function automatic logic [511:0] key_of(int s, int gen);
        logic [511:0] k;
        for (int d = 0; d < 16; d++) k[d*32 +: 32] = kval(s, d, gen);
        return k;
    endfunction

    task automatic chk(bit ok, string req, logic [511:0] act, logic [511:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [11:0] a, logic [31:0] v);
        @(negedge clk); wr = 1'b1; addr = a; wdata = v;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic bus_read(logic [11:0] a, output logic [31:0] v);
        @(negedge clk); rd = 1'b1; addr = a;
        @(negedge clk); rd = 1'b0;
        chk(rvalid === 1'b1, "R9", 512'(rvalid), 512'd1);
        v = rdata;
        @(negedge clk);
        chk(rvalid === 1'b0, "R9", 512'(rvalid), 512'd0);
    endtask

    task automatic look(int s, bit ev, logic [511:0] ek, logic [7:0] ed, logic [7:0] ec, string req);
        @(negedge clk); lk_slot = 3'(s);
        @(negedge clk);
        chk(lk_valid === ev, req, 512'(lk_valid), 512'(ev));
        chk(lk_key === ek, req, lk_key, ek);
        chk(lk_dus === ed && lk_cap === ec, req, {lk_dus, lk_cap}, {ed, ec});
    endtask

    task automatic read_expect(logic [11:0] a, logic [31:0] e, string req);
        logic [31:0] v;
        bus_read(a, v);
        chk(v === e, req, 512'(v), 512'(e));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: everything zero after reset
        for (int s = 0; s < NSLOT; s++) begin
            for (int d = 0; d < 32; d++) read_expect(a_of(s, d), 32'h0, "R1");
            look(s, 1'b0, '0, 8'h0, 8'h0, "R1");
        end
        // R2: fill every slot, control written last with reserved bits set
        for (int s = 0; s < NSLOT; s++) begin
            for (int d = 0; d < 16; d++) bus_write(a_of(s, d), kval(s, d, 0));
            bus_write(a_of(s, 17), 32'hC0DE_0000 + 32'(s));
            // R4: keys staged, not yet valid
            look(s, 1'b0, '0, 8'h0, 8'h0, "R4");
            bus_write(a_of(s, 16), 32'h7FFF_0000 | {16'h0, cap_of(s), dus_of(s)} | 32'h8000_0000);
        end
        for (int s = 0; s < NSLOT; s++) begin
            for (int d = 0; d < 16; d++) read_expect(a_of(s, d), kval(s, d, 0), "R2");
            read_expect(a_of(s, 17), 32'hC0DE_0000 + 32'(s), "R2");
            read_expect(a_of(s, 16), {1'b1, 15'h0, cap_of(s), dus_of(s)}, "R3");
            look(s, 1'b1, key_of(s, 0), dus_of(s), cap_of(s), "R4");
        end
        // R5: rewrite one key dword of slot 1
        bus_write(a_of(1, 5), kval(1, 5, 1));
        read_expect(a_of(1, 16), {16'h0, cap_of(1), dus_of(1)}, "R5");
        look(1, 1'b0, '0, 8'h0, 8'h0, "R5");
        look(0, 1'b1, key_of(0, 0), dus_of(0), cap_of(0), "R5");
        for (int d = 0; d < 16; d++) bus_write(a_of(1, d), kval(1, d, 1));
        look(1, 1'b0, '0, 8'h0, 8'h0, "R5");
        bus_write(a_of(1, 16), {1'b1, 15'h0, cap_of(1), dus_of(1)});
        look(1, 1'b1, key_of(1, 1), dus_of(1), cap_of(1), "R5");
        // R6: clear slot 2 completely
        bus_write(a_of(2, 16), 32'h0);
        look(2, 1'b0, '0, 8'h0, 8'h0, "R6");
        for (int d = 0; d < 18; d++) bus_write(a_of(2, d), 32'h0);
        for (int d = 0; d < 18; d++) read_expect(a_of(2, d), 32'h0, "R6");
        // R7: holes and out-of-array writes ignored
        for (int d = 18; d < 32; d++) bus_write(a_of(0, d), 32'hFFFF_FFFF);
        bus_write(12'(BASE - 4), 32'hFFFF_FFFF);
        bus_write(12'(BASE + NSLOT * 128), 32'hFFFF_FFFF);
        bus_write(12'h000, 32'hFFFF_FFFF);
        for (int d = 18; d < 32; d++) read_expect(a_of(0, d), 32'h0, "R7");
        read_expect(12'(BASE - 4), 32'h0, "R7");
        read_expect(12'(BASE + NSLOT * 128), 32'h0, "R7");
        for (int s = 0; s < NSLOT; s++) begin
            if (s == 2) look(s, 1'b0, '0, 8'h0, 8'h0, "R7");
            else look(s, 1'b1, key_of(s, (s == 1) ? 1 : 0), dus_of(s), cap_of(s), "R7");
        end
        // R8: out-of-range slot numbers
        for (int s = NSLOT; s < 8; s++) look(s, 1'b0, '0, 8'h0, 8'h0, "R8");
        // R10: result follows a change of slot number in one cycle
        @(negedge clk); lk_slot = 3'd3;
        @(negedge clk); lk_slot = 3'd0;
        chk(lk_cap === cap_of(3), "R10", 512'(lk_cap), 512'(cap_of(3)));
        @(negedge clk);
        chk(lk_cap === cap_of(0), "R10", 512'(lk_cap), 512'(cap_of(0)));
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule